// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership tokens that two independent agents, a left port and a right port, use to reserve shared resources. Each token is a state machine kept apart from any data storage. A port claims a token by writing 0 to it. It gives the token back, or drops a claim it has not yet been granted, by writing 1. When a port reads a token it learns whether it currently holds it. The logic is fully synchronous to one clock and has an active-low reset.

Each token also remembers a claim that the non-holding side made while the other side held it. When the holder gives the token back, that waiting claim becomes ownership in the same clock edge, so the waiting side does not have to poll and re-request. If both sides claim a free token in the same cycle, the left port wins and the right port's claim is kept waiting.

A port reaches the tokens only while its token-select strobe is high and its memory-select input is low. The low address bits pick the token. Only bit 0 of the write data carries meaning. A read result is registered and copied onto every bit of that port's read bus.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset every token is free with no waiting claims, and both read buses hold all ones.
- R2: The token is selected by address bits [2:0] (with the default of eight tokens). Address bits above those have no effect on which token is accessed.
- R3: On a write, only data bit 0 is used: a value of 0 claims the token and a value of 1 gives it back or drops a claim. The other data bits have no effect.
- R4: Writing 0 to a free token makes the writer the holder. A read then returns all zeros on the holder's port and all ones on the other port.
- R5: A claim from the side that does not hold the token leaves the holder unchanged. The claim is kept waiting.
- R6: When the holder writes 1 while the other side has a claim waiting, ownership passes to the other side at that clock edge.
- R7: When the holder writes 1 and no claim is waiting, the token becomes free and both ports read all ones.
- R8: If the non-holding side writes 1, its waiting claim is dropped. A later release by the holder then frees the token.
- R9: If both ports write 0 to the same free token in one cycle, only the left port becomes the holder. The right port's claim is kept waiting.
- R10: A port performs no access unless its token-select is 1 and its memory-select is 0. In any other case its strobes change no token and do not update its read bus.
- R11: A read updates the port's read bus at the clock edge that samples it. The value reflects the token state before any write made in that same cycle, and the bus holds that value until the port's next read.
- R12: Tokens are independent: an access to one token does not change any other token. A holder that writes 0 again keeps the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_sel | input | 1 | Left token-select strobe, active high |
| l_mem_sel | input | 1 | Left memory-select; must be 0 for a token access |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_addr | input | ADDR_W | Left address; the low bits pick the token |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left registered read result, replicated on all bits |
| r_sem_sel | input | 1 | Right token-select strobe, active high |
| r_mem_sel | input | 1 | Right memory-select; must be 0 for a token access |
| r_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_addr | input | ADDR_W | Right address; the low bits pick the token |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right registered read result, replicated on all bits |

## Verification
The bench targets the handover cases. In one, a claim waits and the holder then releases. A design without the waiting latch would leave the token free instead of handing it over. In another, the waiting claim is dropped before the release. A design that never cleared the latch would hand the token to a side that no longer wants it. The same-cycle claim on a free token is checked so that a design granting both sides, or granting the right side, is caught. The remaining checks cover address aliasing through the upper bits, data bits 7..1 being ignored, and accesses blocked by the select inputs. They also cover a read taken in the very cycle the other port releases, where a design that passed the new state straight through would report the post-write value instead of the captured one.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_e;

    typedef struct packed {
        sem_owner_e owner;
        logic       wait_l;
        logic       wait_r;
    } sem_state_t;

    localparam sem_state_t SEM_FREE = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              sem_sel,
    input  logic              mem_sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_SEM-1:0] claim_vec,
    output logic [NUM_SEM-1:0] give_vec,
    output logic               rd_en,
    output logic [IDX_W-1:0]   idx
);

    logic access;
    logic wr_en;
    logic unused_hi;

    assign access = sem_sel && !mem_sel;
    assign wr_en  = access && we;
    assign rd_en  = access && !we;
    assign idx    = addr[IDX_W-1:0];

    generate
        if (ADDR_W > IDX_W && DATA_W > 1) begin : g_unused_both
            assign unused_hi = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
        end else if (ADDR_W > IDX_W) begin : g_unused_addr
            assign unused_hi = ^addr[ADDR_W-1:IDX_W];
        end else if (DATA_W > 1) begin : g_unused_data
            assign unused_hi = ^wdata[DATA_W-1:1];
        end else begin : g_unused_none
            assign unused_hi = 1'b0;
        end
    endgenerate

    always_comb begin
        claim_vec = '0;
        give_vec  = '0;
        for (int i = 0; i < NUM_SEM; i++) begin
            if (wr_en && (idx == IDX_W'(i))) begin
                claim_vec[i] = !wdata[0];
                give_vec[i]  = wdata[0];
            end
        end
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_claim,
    input  logic l_give,
    input  logic r_claim,
    input  logic r_give,
    output logic held_l,
    output logic held_r
);

    sem_state_t st_d, st_q;

    always_comb begin
        logic wl_d;
        logic wr_d;
        st_d = st_q;
        wl_d = l_claim ? 1'b1 : (l_give ? 1'b0 : st_q.wait_l);
        wr_d = r_claim ? 1'b1 : (r_give ? 1'b0 : st_q.wait_r);
        unique case (st_q.owner)
            OWN_NONE: begin
                if (l_claim) begin
                    st_d.owner  = OWN_LEFT;
                    st_d.wait_l = 1'b0;
                    st_d.wait_r = r_claim;
                end else if (r_claim) begin
                    st_d.owner  = OWN_RIGHT;
                    st_d.wait_l = 1'b0;
                    st_d.wait_r = 1'b0;
                end else begin
                    st_d = SEM_FREE;
                end
            end
            OWN_LEFT: begin
                st_d.wait_l = 1'b0;
                if (l_give) begin
                    st_d.owner  = wr_d ? OWN_RIGHT : OWN_NONE;
                    st_d.wait_r = 1'b0;
                end else begin
                    st_d.wait_r = wr_d;
                end
            end
            OWN_RIGHT: begin
                st_d.wait_r = 1'b0;
                if (r_give) begin
                    st_d.owner  = wl_d ? OWN_LEFT : OWN_NONE;
                    st_d.wait_l = 1'b0;
                end else begin
                    st_d.wait_l = wl_d;
                end
            end
            default: st_d = SEM_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEM_FREE;
        else        st_q <= st_d;
    end

    assign held_l = (st_q.owner == OWN_LEFT);
    assign held_r = (st_q.owner == OWN_RIGHT);

endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] held_vec,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = {DATA_W{~held_vec[idx]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '1;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_mem_sel,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_sel,
    input  logic              r_mem_sel,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int IDX_W = $clog2(NUM_SEM);

    logic [NUM_SEM-1:0] l_claim_vec, l_give_vec;
    logic [NUM_SEM-1:0] r_claim_vec, r_give_vec;
    logic [NUM_SEM-1:0] held_l_vec, held_r_vec;
    logic               l_rd_en, r_rd_en;
    logic [IDX_W-1:0]   l_idx, r_idx;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sem_sel(l_sem_sel), .mem_sel(l_mem_sel), .we(l_we),
        .addr(l_addr), .wdata(l_wdata),
        .claim_vec(l_claim_vec), .give_vec(l_give_vec),
        .rd_en(l_rd_en), .idx(l_idx)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sem_sel(r_sem_sel), .mem_sel(r_mem_sel), .we(r_we),
        .addr(r_addr), .wdata(r_wdata),
        .claim_vec(r_claim_vec), .give_vec(r_give_vec),
        .rd_en(r_rd_en), .idx(r_idx)
    );

    generate
        for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
            sem_cell u_cell (
                .clk(clk), .rst_n(rst_n),
                .l_claim(l_claim_vec[g]), .l_give(l_give_vec[g]),
                .r_claim(r_claim_vec[g]), .r_give(r_give_vec[g]),
                .held_l(held_l_vec[g]), .held_r(held_r_vec[g])
            );
        end
    endgenerate

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .idx(l_idx),
        .held_vec(held_l_vec), .rdata(l_rdata)
    );

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .idx(r_idx),
        .held_vec(held_r_vec), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sem_sel,
    input logic               l_mem_sel,
    input logic               l_we,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sem_sel,
    input logic               r_mem_sel,
    input logic               r_we,
    input logic [ADDR_W-1:0]  r_addr,
    input logic [DATA_W-1:0]  r_wdata,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] held_l_vec,
    input logic [NUM_SEM-1:0] held_r_vec
);

    logic             l_acc, r_acc;
    logic [IDX_W-1:0] li, ri;

    assign l_acc = l_sem_sel && !l_mem_sel;
    assign r_acc = r_sem_sel && !r_mem_sel;
    assign li    = l_addr[IDX_W-1:0];
    assign ri    = r_addr[IDX_W-1:0];

    // R4: a token never has two holders
    p_single_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_l_vec & held_r_vec) == '0);

    // R4: the read result is replicated on every bit
    p_replicated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    // R11: the left read bus holds between reads
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_acc && !l_we) |=> $stable(l_rdata));

    // R10: no access on either port leaves every token as it was
    p_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_acc && !r_acc) |=> ($stable(held_l_vec) && $stable(held_r_vec)));

    // R9: a same-cycle claim on a free token goes to the left port
    p_left_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && r_acc && l_we && r_we && !l_wdata[0] && !r_wdata[0] &&
         li == ri && !held_l_vec[li] && !held_r_vec[li])
        |=> held_l_vec[$past(li)]);

    // R7: a left release takes the token away from the left port
    p_release_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && l_we && l_wdata[0] && held_l_vec[li])
        |=> !held_l_vec[$past(li)]);

endmodule

bind hw_sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_sel(l_mem_sel), .l_we(l_we),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_sel(r_mem_sel), .r_we(r_we),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .held_l_vec(held_l_vec), .held_r_vec(held_r_vec)
);

// File: tb/test_hw_sem_bank.sv
module test_hw_sem_bank;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam logic [7:0] OWN  = 8'h00;
    localparam logic [7:0] NOWN = 8'hFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l_sem_sel = 0, l_mem_sel = 0, l_we = 0;
    logic [ADDR_W-1:0] l_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0;
    logic [DATA_W-1:0] l_rdata;
    logic              r_sem_sel = 0, r_mem_sel = 0, r_we = 0;
    logic [ADDR_W-1:0] r_addr = '0;
    logic [DATA_W-1:0] r_wdata = '0;
    logic [DATA_W-1:0] r_rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_sem_bank #(.NUM_SEM(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hw_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_mem_sel(l_mem_sel), .l_we(l_we),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_sel(r_sem_sel), .r_mem_sel(r_mem_sel), .r_we(r_we),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_ports();
        l_sem_sel = 0; l_mem_sel = 0; l_we = 0;
        r_sem_sel = 0; r_mem_sel = 0; r_we = 0;
    endtask

    // one cycle with explicit strobes on both ports
    task automatic cycle2(input logic ls, lm, lw, input logic [12:0] la, input logic [7:0] ld,
                          input logic rs, rm, rw, input logic [12:0] ra, input logic [7:0] rd);
        @(negedge clk);
        l_sem_sel = ls; l_mem_sel = lm; l_we = lw; l_addr = la; l_wdata = ld;
        r_sem_sel = rs; r_mem_sel = rm; r_we = rw; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        idle_ports();
    endtask

    task automatic wr_l(input logic [12:0] a, input logic [7:0] d);
        cycle2(1, 0, 1, a, d, 0, 0, 0, '0, '0);
    endtask

    task automatic wr_r(input logic [12:0] a, input logic [7:0] d);
        cycle2(0, 0, 0, '0, '0, 1, 0, 1, a, d);
    endtask

    task automatic rd_l(input logic [12:0] a, output logic [7:0] v);
        cycle2(1, 0, 0, a, '0, 0, 0, 0, '0, '0);
        v = l_rdata;
    endtask

    task automatic rd_r(input logic [12:0] a, output logic [7:0] v);
        cycle2(0, 0, 0, '0, '0, 1, 0, 0, a, '0);
        v = r_rdata;
    endtask

    task automatic expect_both(string req, input logic [12:0] a, logic [7:0] el, logic [7:0] er);
        logic [7:0] v;
        rd_l(a, v); check({req, " left"}, v, el);
        rd_r(a, v); check({req, " right"}, v, er);
    endtask

    task automatic t_reset();
        check("R1 l_rdata at reset", l_rdata, NOWN);
        check("R1 r_rdata at reset", r_rdata, NOWN);
        for (int i = 0; i < 8; i++) expect_both("R1 free after reset", 13'(i), NOWN, NOWN);
    endtask

    task automatic t_claim_release();
        wr_l(13'd2, 8'h00);
        expect_both("R4 left holds", 13'd2, OWN, NOWN);
        wr_l(13'd2, 8'h01);
        expect_both("R7 freed", 13'd2, NOWN, NOWN);
        wr_r(13'd2, 8'h00);
        expect_both("R4 right holds", 13'd2, NOWN, OWN);
        wr_r(13'd2, 8'h01);
        expect_both("R7 right freed", 13'd2, NOWN, NOWN);
    endtask

    task automatic t_waiting();
        wr_l(13'd5, 8'h00);
        wr_r(13'd5, 8'h00);
        expect_both("R5 holder kept", 13'd5, OWN, NOWN);
        wr_l(13'd5, 8'h01);
        expect_both("R6 handover to right", 13'd5, NOWN, OWN);
        wr_r(13'd5, 8'h01);
        expect_both("R7 free after handover", 13'd5, NOWN, NOWN);
    endtask

    task automatic t_withdraw();
        wr_l(13'd1, 8'h00);
        wr_r(13'd1, 8'h00);
        wr_r(13'd1, 8'h01);
        expect_both("R8 still left", 13'd1, OWN, NOWN);
        wr_l(13'd1, 8'h01);
        expect_both("R8 freed after withdraw", 13'd1, NOWN, NOWN);
    endtask

    task automatic t_same_cycle();
        cycle2(1, 0, 1, 13'd3, 8'h00, 1, 0, 1, 13'd3, 8'h00);
        expect_both("R9 left wins", 13'd3, OWN, NOWN);
        wr_l(13'd3, 8'h01);
        expect_both("R9 loser waits then owns", 13'd3, NOWN, OWN);
        wr_r(13'd3, 8'h01);
    endtask

    task automatic t_alias();
        logic [7:0] v;
        wr_l(13'h1F04, 8'h00);
        rd_r(13'h0004, v); check("R2 alias right", v, NOWN);
        rd_l(13'h0AC4, v); check("R2 alias left", v, OWN);
        rd_l(13'h0AC5, v); check("R2 neighbour untouched", v, NOWN);
        wr_l(13'h0804, 8'h01);
        expect_both("R2 release via alias", 13'd4, NOWN, NOWN);
    endtask

    task automatic t_data_bit();
        wr_l(13'd6, 8'hF1);
        expect_both("R3 bit0=1 no claim", 13'd6, NOWN, NOWN);
        wr_l(13'd6, 8'hFE);
        expect_both("R3 bit0=0 claims", 13'd6, OWN, NOWN);
        wr_l(13'd6, 8'h81);
        expect_both("R3 release upper bits set", 13'd6, NOWN, NOWN);
    endtask

    task automatic t_select();
        logic [7:0] v;
        cycle2(1, 1, 1, 13'd0, 8'h00, 0, 0, 0, '0, '0);
        cycle2(0, 0, 1, 13'd0, 8'h00, 1, 1, 1, 13'd0, 8'h00);
        expect_both("R10 blocked writes", 13'd0, NOWN, NOWN);
        wr_l(13'd0, 8'h00);
        rd_l(13'd0, v); check("R10 owned read", v, OWN);
        cycle2(1, 1, 0, 13'd1, 8'h00, 0, 0, 0, '0, '0);
        check("R10 blocked read keeps bus", l_rdata, OWN);
        wr_l(13'd0, 8'h01);
    endtask

    task automatic t_capture();
        logic [7:0] v;
        wr_l(13'd7, 8'h00);
        rd_l(13'd7, v); check("R11 left read", v, OWN);
        rd_r(13'd7, v); check("R11 right read", v, NOWN);
        check("R11 left bus held", l_rdata, OWN);
        wr_r(13'd7, 8'h00);
        // right reads while left releases in the same cycle
        cycle2(1, 0, 1, 13'd7, 8'h01, 1, 0, 0, 13'd7, 8'h00);
        check("R11 pre-write captured", r_rdata, NOWN);
        rd_r(13'd7, v); check("R11 after handover", v, OWN);
        wr_r(13'd7, 8'h01);
    endtask

    task automatic t_independent();
        logic [7:0] v;
        wr_l(13'd2, 8'h00);
        wr_l(13'd2, 8'h00);
        rd_l(13'd2, v); check("R12 re-claim keeps", v, OWN);
        for (int i = 0; i < 8; i++) begin
            if (i != 2) begin
                rd_r(13'(i), v); check("R12 others free", v, NOWN);
            end
        end
        wr_l(13'd2, 8'h01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_claim_release();
        t_waiting();
        t_withdraw();
        t_same_cycle();
        t_alias();
        t_data_bit();
        t_select();
        t_capture();
        t_independent();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule